// File: doc/BRIEF.md
# Receive Byte Ordering Aligner

This block sits right after a 1:2 byte deserializer in a serial receive path. Each input word holds two lanes. A lane is one symbol wide in single-width operation and two symbols wide in double-width operation. The block makes sure that a known lane-wide ordering pattern comes out in the lower lane of the output word.

When the sync status from the word aligner rises, the block arms a search. The first valid word that carries the pattern settles the lane mapping:

- **Pattern in the lower lane:** the word passes straight through.
- **Pattern in the upper lane:** the block emits a pad lane in the lower position. This delays the stream by exactly one lane, so the pattern leaves in the lower lane of the next word.

After that one correction the search disarms. It re-arms only on the next rising edge of sync status.

The data interface is a valid-only stream with no back-pressure. The deserializer cannot be stalled, so the sink must accept every word for which `out_valid` is high. `out_valid` repeats `in_valid` exactly one clock later. Symbols are compared over their full width, so with 9-bit symbols the control flag in bit 8 takes part in the match.

Top module: `rx_byte_order_align`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. `out_data` changes only in a cycle that follows a valid input word.
- R2: If the armed search finds the pattern in the lower lane (bits [LANE_W-1:0]), the word is output unchanged, the lane map becomes direct and `order_done` rises together with that output word.
- R3: If the armed search finds the pattern only in the upper lane, the output word is: lower lane = pad lane (PAD_SYM in every symbol slot), upper lane = input lower lane. Every later word is output as lower lane = previous input upper lane, upper lane = current input lower lane. `order_done` rises with the pad word.
- R4: A search is armed only by a rising edge of `sync_status`, and the word arriving in the edge cycle is itself searched. Patterns seen while disarmed leave the lane map unchanged. An armed search that sees no pattern stays armed.
- R5: After one correction, the search is disarmed. Later patterns in either lane do not change the lane map, and `order_done` stays high while `sync_status` stays high.
- R6: `sync_status` low clears `order_done` by the next clock and disarms the search. `order_done` only ever rises together with a valid output word.
- R7: The match covers every bit of every symbol, including the control flag in bit 8 of a 9-bit symbol. A data symbol whose low 8 bits equal a pattern symbol does not match.
- R8: If both lanes carry the pattern, the lower lane wins and no pad is inserted.
- R9: In double-width operation the pattern is two symbols: A1 in lane bits [SYM_W-1:0] and A2 above it. Both symbols must match; a lane with A1 but a different second symbol is not a match.
- R10: A correction to the lower lane made while the map is shifted returns the map to direct. The held upper-lane symbol from the previous word is dropped.
- R11: After reset, `out_valid` = 0, `out_data` = 0, `order_done` = 0, the lane map is direct and the search is disarmed.
- R12: There is no back-pressure. Back-to-back valid words are all accepted and all produce output words with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive parallel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_status | input | 1 | Word-aligner sync indication; a rising edge arms the search |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 2*SYM_W*LANE_SYMS | Deserialized word; lower lane in the low half |
| out_valid | output | 1 | Output word strobe, one cycle after `in_valid` |
| out_data | output | 2*SYM_W*LANE_SYMS | Lane-ordered word |
| order_done | output | 1 | High from the corrected word until `sync_status` falls |

## Verification
A wrong lane map or a stale held symbol shows up on the very next valid output word. Either a pad lane appears where data belonged, or lanes are swapped or duplicated relative to the one-lane-delayed stream. A wrong armed state shows up on the first valid word that carries the pattern after a sync edge: a pad is missing, or a pad is inserted where none should be. A wrong `order_done` shows up one clock after the sync change or the correcting word. Each of these is visible within one output word of the faulty state, so a per-word comparison against a reference map catches it immediately.

// File: rtl/rbo_pkg.sv
`timescale 1ns/1ps
package rbo_pkg;
  // Lane mapping applied by the steering stage.
  typedef enum logic {
    MAP_DIRECT  = 1'b0,
    MAP_SHIFTED = 1'b1
  } lane_map_e;

  localparam int unsigned LANE_LO = 0;
  localparam int unsigned LANE_HI = 1;
  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/rbo_lane_match.sv
`timescale 1ns/1ps
module rbo_lane_match #(
  parameter int unsigned LANE_W = 18,
  parameter int unsigned LANES = 2,
  parameter logic [LANE_W-1:0] LANE_PATTERN = '0
) (
  input  logic [LANES*LANE_W-1:0] word,
  output logic [LANES-1:0]        hit
);
  // Full-width compare per lane, control bits included.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = (word[g*LANE_W +: LANE_W] == LANE_PATTERN);
  end
endmodule

// File: rtl/rbo_order_ctrl.sv
`timescale 1ns/1ps
module rbo_order_ctrl
  import rbo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_status,
  input  logic                 in_valid,
  input  logic [NUM_LANES-1:0] hit,
  output logic                 fix_lo,
  output logic                 fix_hi,
  output logic                 order_done
);
  logic sync_q;
  logic armed;
  logic sync_rise;
  logic search;

  assign sync_rise = sync_status & ~sync_q;
  // The word arriving with the edge is searched too.
  assign search    = in_valid & sync_status & (armed | sync_rise);
  // Lower lane has priority when both lanes match.
  assign fix_lo    = search & hit[LANE_LO];
  assign fix_hi    = search & hit[LANE_HI] & ~hit[LANE_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 1'b0;
      armed      <= 1'b0;
      order_done <= 1'b0;
    end else begin
      sync_q <= sync_status;
      if (!sync_status) begin
        armed      <= 1'b0;
        order_done <= 1'b0;
      end else if (fix_lo || fix_hi) begin
        armed      <= 1'b0;
        order_done <= 1'b1;
      end else if (sync_rise) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rbo_lane_steer.sv
`timescale 1ns/1ps
module rbo_lane_steer
  import rbo_pkg::*;
#(
  parameter int unsigned LANE_W = 18,
  parameter logic [LANE_W-1:0] PAD_LANE = '0,
  localparam int unsigned WORD_W = NUM_LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              fix_lo,
  input  logic              fix_hi,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  lane_map_e   lane_map;
  logic [LANE_W-1:0] held_hi;
  logic [LANE_W-1:0] cur_lo;
  logic [LANE_W-1:0] cur_hi;

  assign cur_lo = in_data[LANE_LO*LANE_W +: LANE_W];
  assign cur_hi = in_data[LANE_HI*LANE_W +: LANE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_map  <= MAP_DIRECT;
      held_hi   <= PAD_LANE;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (fix_lo) begin
          lane_map <= MAP_DIRECT;
          out_data <= in_data;
        end else if (fix_hi) begin
          // Pad fills the lower lane; the stream slips by one lane.
          lane_map <= MAP_SHIFTED;
          out_data <= {cur_lo, PAD_LANE};
          held_hi  <= cur_hi;
        end else if (lane_map == MAP_SHIFTED) begin
          out_data <= {cur_lo, held_hi};
          held_hi  <= cur_hi;
        end else begin
          out_data <= in_data;
        end
      end
    end
  end
endmodule

// File: rtl/rx_byte_order_align.sv
`timescale 1ns/1ps
module rx_byte_order_align
  import rbo_pkg::*;
#(
  parameter int unsigned SYM_W = 9,
  parameter int unsigned LANE_SYMS = 2,
  parameter logic [2*SYM_W-1:0] PATTERN_PAIR = {9'h13C, 9'h1BC},
  parameter logic [SYM_W-1:0] PAD_SYM = 9'h19C,
  localparam int unsigned LANE_W = SYM_W * LANE_SYMS,
  localparam int unsigned WORD_W = NUM_LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_status,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              order_done
);
  // Single width uses only the first pattern symbol.
  localparam logic [LANE_W-1:0] LANE_PATTERN = PATTERN_PAIR[LANE_W-1:0];
  localparam logic [LANE_W-1:0] PAD_LANE     = {LANE_SYMS{PAD_SYM}};

  logic [NUM_LANES-1:0] hit;
  logic fix_lo;
  logic fix_hi;

  rbo_lane_match #(
    .LANE_W      (LANE_W),
    .LANES       (NUM_LANES),
    .LANE_PATTERN(LANE_PATTERN)
  ) u_match (
    .word(in_data),
    .hit (hit)
  );

  rbo_order_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_status(sync_status),
    .in_valid   (in_valid),
    .hit        (hit),
    .fix_lo     (fix_lo),
    .fix_hi     (fix_hi),
    .order_done (order_done)
  );

  rbo_lane_steer #(
    .LANE_W  (LANE_W),
    .PAD_LANE(PAD_LANE)
  ) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .fix_lo   (fix_lo),
    .fix_hi   (fix_hi),
    .out_valid(out_valid),
    .out_data (out_data)
  );
endmodule

// File: rtl/rx_byte_order_align_chk.sv
`timescale 1ns/1ps
module rx_byte_order_align_chk #(
  parameter int unsigned LANE_W = 18,
  parameter logic [LANE_W-1:0] LANE_PATTERN = '0,
  parameter logic [LANE_W-1:0] PAD_LANE = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_status,
  input logic                in_valid,
  input logic [2*LANE_W-1:0] in_data,
  input logic                out_valid,
  input logic [2*LANE_W-1:0] out_data,
  input logic                order_done
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  p_lo_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $rose(sync_status) && in_data[LANE_W-1:0] == LANE_PATTERN)
    |=> (out_data == $past(in_data)) && order_done);
  p_pad_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $rose(sync_status) && in_data[2*LANE_W-1:LANE_W] == LANE_PATTERN
     && in_data[LANE_W-1:0] != LANE_PATTERN)
    |=> (out_data[LANE_W-1:0] == PAD_LANE)
        && (out_data[2*LANE_W-1:LANE_W] == $past(in_data[LANE_W-1:0]))
        && order_done);
  p_done_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (order_done && sync_status) |=> order_done);
  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_status |=> !order_done);
  p_done_with_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(order_done) |-> out_valid);
endmodule

bind rx_byte_order_align rx_byte_order_align_chk #(
  .LANE_W      (LANE_W),
  .LANE_PATTERN(LANE_PATTERN),
  .PAD_LANE    (PAD_LANE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_status(sync_status),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .order_done (order_done)
);

// File: tb/test_rx_byte_order_align.sv
`timescale 1ns/1ps
module test_rx_byte_order_align;
  localparam int unsigned SYM_W  = 9;
  localparam int unsigned LSYMS  = 2;
  localparam int unsigned LANE_W = SYM_W * LSYMS;
  localparam int unsigned WORD_W = 2 * LANE_W;
  localparam logic [LANE_W-1:0] PAT  = {9'h13C, 9'h1BC};
  localparam logic [LANE_W-1:0] PADL = {9'h19C, 9'h19C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_status = 1'b0;
  logic in_valid = 1'b0;
  logic [WORD_W-1:0] in_data = '0;
  logic out_valid;
  logic [WORD_W-1:0] out_data;
  logic order_done;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference state derived from the requirements.
  logic m_sync_q = 1'b0, m_armed = 1'b0, m_shift = 1'b0;
  logic [LANE_W-1:0] m_held = PADL;
  logic e_valid = 1'b0, e_done = 1'b0;
  logic [WORD_W-1:0] e_data = '0;

  always #2 clk = ~clk;

  rx_byte_order_align i_rx_byte_order_align (
    .clk(clk), .rst_n(rst_n), .sync_status(sync_status),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .order_done(order_done)
  );

  function automatic logic [WORD_W-1:0] mk(input logic [LANE_W-1:0] hi, input logic [LANE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [LANE_W-1:0] rand_lane();
    int unsigned r = $urandom % 10;
    case (r)
      0, 1:    return PAT;
      2:       return PAT ^ 18'h00100;                               // control flag flipped (R7)
      3:       return {9'($urandom), PAT[SYM_W-1:0]};                // half pattern (R9)
      default: return LANE_W'($urandom);
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one cycle, update the reference, check after the edge.
  task automatic step(input logic s, input logic v, input logic [WORD_W-1:0] d, input string req);
    logic rise, search, mlo, mhi;
    logic [LANE_W-1:0] lo, hi;
    sync_status = s; in_valid = v; in_data = d;
    lo = d[LANE_W-1:0]; hi = d[WORD_W-1:LANE_W];
    rise = s & ~m_sync_q;
    search = v & s & (m_armed | rise);
    mlo = (lo == PAT); mhi = (hi == PAT);
    e_valid = v;
    if (v) begin
      if (search && mlo) begin e_data = d; m_shift = 1'b0; end
      else if (search && mhi) begin e_data = {lo, PADL}; m_held = hi; m_shift = 1'b1; end
      else if (m_shift) begin e_data = {lo, m_held}; m_held = hi; end
      else e_data = d;
    end
    if (!s) begin m_armed = 1'b0; e_done = 1'b0; end
    else if (search && (mlo || mhi)) begin m_armed = 1'b0; e_done = 1'b1; end
    else if (rise) m_armed = 1'b1;
    m_sync_q = s;
    @(negedge clk);
    check(req, "out_valid", WORD_W'(out_valid), WORD_W'(e_valid));
    check(req, "order_done", WORD_W'(order_done), WORD_W'(e_done));
    if (e_valid) check(req, "out_data", out_data, e_data);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [LANE_W-1:0] d0, d1, d2, d3;
    void'($urandom(32'h5EED_0B0D));
    d0 = 18'h00A11; d1 = 18'h00B22; d2 = 18'h00C33; d3 = 18'h00D44;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "out_valid", WORD_W'(out_valid), '0);
    check("R11", "out_data", out_data, '0);
    check("R11", "order_done", WORD_W'(order_done), '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: pattern while disarmed is ignored
    step(1'b0, 1'b1, mk(PAT, d0), "R4");
    // R3: rise with pattern in upper lane -> pad, then slipped stream
    step(1'b1, 1'b1, mk(PAT, d1), "R3");
    step(1'b1, 1'b1, mk(d3, d2), "R3");
    step(1'b1, 1'b0, mk(d0, d0), "R1");
    step(1'b1, 1'b1, mk(d1, d0), "R3");
    // R5: disarmed after correction
    step(1'b1, 1'b1, mk(PAT, d2), "R5");
    step(1'b1, 1'b1, mk(d3, PAT), "R5");
    step(1'b1, 1'b1, mk(d0, d1), "R5");
    // R6: sync loss clears done
    step(1'b0, 1'b1, mk(d2, d3), "R6");
    // R10 + R2: lower-lane correction returns to direct
    step(1'b1, 1'b1, mk(d1, PAT), "R10");
    step(1'b1, 1'b1, mk(d2, d3), "R2");
    step(1'b0, 1'b0, mk(d2, d3), "R6");
    // R8: both lanes match
    step(1'b1, 1'b1, mk(PAT, PAT), "R8");
    step(1'b0, 1'b1, mk(d0, d1), "R6");
    // R7: control flag differs -> no match; search stays armed (R4)
    step(1'b1, 1'b1, mk(PAT ^ 18'h00100, d0), "R7");
    step(1'b1, 1'b1, mk(PAT, d1), "R4");
    step(1'b1, 1'b1, mk(d3, d2), "R4");
    step(1'b0, 1'b1, mk(d3, d2), "R6");
    // R9: only first pattern symbol present -> no match
    step(1'b1, 1'b1, mk({9'h0AB, PAT[SYM_W-1:0]}, d0), "R9");
    step(1'b1, 1'b1, mk(d1, {9'h0AB, PAT[SYM_W-1:0]}), "R9");
    step(1'b1, 1'b1, mk(d2, PAT), "R9");
    // R12: random back-to-back stream with occasional sync edges
    for (int i = 0; i < 4000; i++) begin
      logic s, v;
      s = (($urandom % 25) == 0) ? ~sync_status : sync_status;
      v = (i % 300 < 150) ? 1'b1 : (($urandom % 5) != 0);
      step(s, v, mk(rand_lane(), rand_lane()), "R12");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule